// File: doc/BRIEF.md
# Multi-Hop Destination Direction Comparator

This combinational block sits in the routing stage of a mesh router that also has two- and three-hop express links. It takes the 8-bit address of the current node and the 8-bit address of a packet's destination. The upper nibble of each address is the X coordinate and the lower nibble is the Y coordinate. For each of the four compass directions it reports whether the destination lies at least one, at least two or at least three hops away. For each axis it also reports an equality node. Port selection logic downstream picks a link from these flags.

The flags carry redundancy. Deeper flags nest inside shallower ones. Opposite directions on one axis exclude each other. The equality node excludes both one-hop flags. A fault checker watches for patterns that break these rules and raises a single fault flag, so a transient upset in the comparator is caught without any added code bits. An injection control, enabled by a test input, complements one chosen output signal before it reaches both the ports and the checker. This lets a test observe detection.

Top module: `mhop_dir_cmp`

## Requirements
- R1: With no injection, `eastHop[k]` (k = 0, 1, 2) is 1 exactly when the destination X exceeds the current X by at least k+1. `westHop[k]` is 1 exactly when the current X exceeds the destination X by at least k+1. X is address bits [7:4], compared unsigned.
- R2: With no injection, `northHop[k]` is 1 exactly when the destination Y exceeds the current Y by at least k+1. `southHop[k]` is 1 exactly when the current Y exceeds the destination Y by at least k+1. Y is address bits [3:0].
- R3: With no injection, `xEqual` is 1 exactly when the two X coordinates match, and `yEqual` is 1 exactly when the two Y coordinates match.
- R4: With no injection, the flags of every direction nest: bit 2 set implies bits 1 and 0 are set, and bit 1 set implies bit 0 is set.
- R5: When `injEn` is 1 and `injSel` is below 14, exactly one output signal is complemented. Values 0 to 2 select east bits 0 to 2, 3 to 5 select west bits 0 to 2, 6 to 8 select north bits 0 to 2, 9 to 11 select south bits 0 to 2, 12 selects `xEqual` and 13 selects `yEqual`. When `injEn` is 0, or `injSel` is 14 or 15, no output changes.
- R6: With no output complemented, `faultDet` is 0 for every address pair.
- R7: On either axis, `faultDet` is 1 when both opposite three-hop flags are set.
- R8: On either axis, `faultDet` is 1 when a three-hop flag is set and either its own one-hop or two-hop flag is clear, or the opposite one-hop or two-hop flag is set.
- R9: On either axis, `faultDet` is 1 when the equality node is set together with either one-hop flag on that axis, or when the equality node and both one-hop flags on that axis are all clear.
- R10: `faultDet` is the OR of the X-axis and Y-axis fault terms, judged on the signals as they appear at the outputs after any injection, and is 0 when neither term holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| curAddr | input | 8 | Current node address, X in [7:4], Y in [3:0] |
| dstAddr | input | 8 | Destination node address, same layout |
| injEn | input | 1 | Enables complementing of the selected output |
| injSel | input | 4 | Index of the output signal to complement |
| eastHop | output | 3 | East distance flags, bit k means at least k+1 hops |
| westHop | output | 3 | West distance flags |
| northHop | output | 3 | North distance flags |
| southHop | output | 3 | South distance flags |
| xEqual | output | 1 | X coordinates equal |
| yEqual | output | 1 | Y coordinates equal |
| faultDet | output | 1 | Inconsistent flag pattern seen |

## Verification
The hardest conditions to reach are the inconsistent patterns. A correct comparator never produces two opposite three-hop flags, or a three-hop flag without its lower flags, so R7 and R8 can only be seen through injection. The stimulus therefore crosses every X coordinate pair with a set of Y pairs and every value of `injSel`. This puts a complemented three-hop, two-hop, one-hop or equality signal on top of every distance from zero to fifteen, in both directions. Directed cases pin down the specific R7, R8 and R9 patterns: a far west destination with east bit 2 forced on, a one-hop east distance with east bit 2 forced on, and equal coordinates with `xEqual` forced off. The exhaustive clean sweep of all 65536 address pairs covers R1 to R4 and R6.

// File: rtl/mhop_pkg.sv
package mhop_pkg;
  localparam int COORD_W = 4;
  localparam int ADDR_W  = 2 * COORD_W;
  localparam int HOPS    = 3;
  localparam int SIG_N   = 4 * HOPS + 2;
  localparam int SEL_W   = $clog2(SIG_N);

  // packed so east occupies the least significant bits
  typedef struct packed {
    logic            eqY;
    logic            eqX;
    logic [HOPS-1:0] south;
    logic [HOPS-1:0] north;
    logic [HOPS-1:0] west;
    logic [HOPS-1:0] east;
  } flipVec_t;

  typedef struct packed {
    logic [HOPS-1:0] pos;
    logic [HOPS-1:0] neg;
    logic            eq;
  } axisFlags_t;
endpackage

// File: rtl/mhop_inject_ctl.sv
module mhop_inject_ctl
  import mhop_pkg::*;
(
  input  logic             injEn,
  input  logic [SEL_W-1:0] injSel,
  output flipVec_t         strobes
);
  logic [SIG_N-1:0] selVec;

  always_comb begin
    selVec = '0;
    for (int i = 0; i < SIG_N; i++) begin
      if (injEn && (int'(injSel) == i)) selVec[i] = 1'b1;
    end
    strobes = flipVec_t'(selVec);
  end

  // at most one signal is ever disturbed
  always_comb begin
    p_single_flip_r5: assert ($onehot0(strobes));
  end
endmodule

// File: rtl/mhop_axis_cmp.sv
module mhop_axis_cmp
  import mhop_pkg::*;
(
  input  logic [COORD_W-1:0] curCoord,
  input  logic [COORD_W-1:0] dstCoord,
  output axisFlags_t         flags
);
  logic              ahead;
  logic              behind;
  logic [COORD_W-1:0] fwdDist;
  logic [COORD_W-1:0] bwdDist;

  assign ahead   = dstCoord > curCoord;
  assign behind  = curCoord > dstCoord;
  assign fwdDist = dstCoord - curCoord;
  assign bwdDist = curCoord - dstCoord;

  generate
    for (genvar k = 0; k < HOPS; k++) begin : g_level
      localparam logic [COORD_W-1:0] THRESH = COORD_W'(k + 1);
      assign flags.pos[k] = ahead  && (fwdDist >= THRESH);
      assign flags.neg[k] = behind && (bwdDist >= THRESH);
    end
  endgenerate

  assign flags.eq = (curCoord == dstCoord);
endmodule

// File: rtl/mhop_datapath.sv
module mhop_datapath
  import mhop_pkg::*;
(
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  flipVec_t          strobes,
  output axisFlags_t        xOut,
  output axisFlags_t        yOut
);
  axisFlags_t xRaw;
  axisFlags_t yRaw;

  mhop_axis_cmp u_xCmp (
    .curCoord(curAddr[ADDR_W-1:COORD_W]),
    .dstCoord(dstAddr[ADDR_W-1:COORD_W]),
    .flags   (xRaw)
  );

  mhop_axis_cmp u_yCmp (
    .curCoord(curAddr[COORD_W-1:0]),
    .dstCoord(dstAddr[COORD_W-1:0]),
    .flags   (yRaw)
  );

  // injection sits after the comparators so the checker sees the upset
  assign xOut.pos = xRaw.pos ^ strobes.east;
  assign xOut.neg = xRaw.neg ^ strobes.west;
  assign xOut.eq  = xRaw.eq  ^ strobes.eqX;
  assign yOut.pos = yRaw.pos ^ strobes.north;
  assign yOut.neg = yRaw.neg ^ strobes.south;
  assign yOut.eq  = yRaw.eq  ^ strobes.eqY;

  always_comb begin
    if (strobes == '0) begin
      for (int k = 1; k < HOPS; k++) begin
        p_nest_r4: assert ((!xOut.pos[k] || xOut.pos[k-1]) && (!xOut.neg[k] || xOut.neg[k-1])
                        && (!yOut.pos[k] || yOut.pos[k-1]) && (!yOut.neg[k] || yOut.neg[k-1]));
      end
      p_axis_excl_r3: assert ($countones({xOut.pos[0], xOut.neg[0], xOut.eq}) == 1
                           && $countones({yOut.pos[0], yOut.neg[0], yOut.eq}) == 1);
    end
  end
endmodule

// File: rtl/mhop_fault_chk.sv
module mhop_fault_chk
  import mhop_pkg::*;
(
  input  axisFlags_t xIn,
  input  axisFlags_t yIn,
  output logic       faultDet
);
  logic [1:0] axisFault;
  axisFlags_t axisIn [2];

  assign axisIn[0] = xIn;
  assign axisIn[1] = yIn;

  generate
    for (genvar a = 0; a < 2; a++) begin : g_axis
      logic [HOPS-1:0] p;
      logic [HOPS-1:0] n;
      logic            bothFar;
      logic            posBroken;
      logic            negBroken;
      logic            eqBroken;

      assign p = axisIn[a].pos;
      assign n = axisIn[a].neg;
      assign bothFar   = p[HOPS-1] & n[HOPS-1];
      assign posBroken = p[HOPS-1] & ~((&p[HOPS-2:0]) & ~(|n[HOPS-2:0]));
      assign negBroken = n[HOPS-1] & ~((&n[HOPS-2:0]) & ~(|p[HOPS-2:0]));
      assign eqBroken  = (axisIn[a].eq & (p[0] | n[0]))
                       | (~axisIn[a].eq & ~p[0] & ~n[0]);
      assign axisFault[a] = bothFar | posBroken | negBroken | eqBroken;
    end
  endgenerate

  assign faultDet = |axisFault;

  // a far flag on both sides must always be caught
  always_comb begin
    p_opposite_far_r7: assert (!((xIn.pos[HOPS-1] && xIn.neg[HOPS-1])
                               || (yIn.pos[HOPS-1] && yIn.neg[HOPS-1])) || faultDet);
  end
endmodule

// File: rtl/mhop_dir_cmp.sv
module mhop_dir_cmp
  import mhop_pkg::*;
(
  input  logic [7:0] curAddr,
  input  logic [7:0] dstAddr,
  input  logic       injEn,
  input  logic [3:0] injSel,
  output logic [2:0] eastHop,
  output logic [2:0] westHop,
  output logic [2:0] northHop,
  output logic [2:0] southHop,
  output logic       xEqual,
  output logic       yEqual,
  output logic       faultDet
);
  flipVec_t   strobes;
  axisFlags_t xFlags;
  axisFlags_t yFlags;

  mhop_inject_ctl u_ctl (
    .injEn  (injEn),
    .injSel (injSel),
    .strobes(strobes)
  );

  mhop_datapath u_dp (
    .curAddr(curAddr),
    .dstAddr(dstAddr),
    .strobes(strobes),
    .xOut   (xFlags),
    .yOut   (yFlags)
  );

  mhop_fault_chk u_chk (
    .xIn     (xFlags),
    .yIn     (yFlags),
    .faultDet(faultDet)
  );

  assign eastHop  = xFlags.pos;
  assign westHop  = xFlags.neg;
  assign northHop = yFlags.pos;
  assign southHop = yFlags.neg;
  assign xEqual   = xFlags.eq;
  assign yEqual   = yFlags.eq;

  always_comb begin
    if (strobes == '0) p_quiet_r6: assert (!faultDet);
  end
endmodule

// File: tb/sim_mhop_dir_cmp.sv
module sim_mhop_dir_cmp;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] curAddr = '0;
  logic [7:0] dstAddr = '0;
  logic       injEn = 1'b0;
  logic [3:0] injSel = '0;
  logic [2:0] eastHop, westHop, northHop, southHop;
  logic       xEqual, yEqual, faultDet;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit driveDone = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [13:0] expVec;
    logic        expFault;
    string       vecTag;
    string       faultTag;
  } item_t;

  item_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  mhop_dir_cmp u0 (
    .curAddr(curAddr), .dstAddr(dstAddr), .injEn(injEn), .injSel(injSel),
    .eastHop(eastHop), .westHop(westHop), .northHop(northHop), .southHop(southHop),
    .xEqual(xEqual), .yEqual(yEqual), .faultDet(faultDet)
  );

  function automatic logic [2:0] hopsAhead(int c, int d);
    logic [2:0] h;
    for (int k = 0; k < 3; k++) h[k] = (d > c) && (d - c >= k + 1);
    return h;
  endfunction

  function automatic logic axisBad(logic [2:0] p, logic [2:0] n, logic a);
    logic bad;
    bad = p[2] & n[2];
    if (p[2] && !(p[1] && p[0] && !n[1] && !n[0])) bad = 1'b1;
    if (n[2] && !(n[1] && n[0] && !p[1] && !p[0])) bad = 1'b1;
    if (a && (p[0] || n[0])) bad = 1'b1;
    if (!a && !p[0] && !n[0]) bad = 1'b1;
    return bad;
  endfunction

  task automatic drive(int cx, int cy, int dx, int dy, bit en, int sel,
                       string vTag, string fTag);
    item_t it;
    logic [13:0] v;
    @(negedge clk);
    curAddr = 8'((cx << 4) | cy);
    dstAddr = 8'((dx << 4) | dy);
    injEn   = en;
    injSel  = 4'(sel);
    v = {dy == cy, dx == cx, hopsAhead(dy, cy), hopsAhead(cy, dy),
         hopsAhead(dx, cx), hopsAhead(cx, dx)};
    if (en && sel < 14) v[sel] = ~v[sel];
    it.expVec   = v;
    it.expFault = axisBad(v[2:0], v[5:3], v[12]) | axisBad(v[8:6], v[11:9], v[13]);
    it.vecTag   = vTag;
    it.faultTag = fTag;
    sb.push_back(it);
  endtask

  // monitor: inputs change at negedge, outputs compared at posedge
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [13:0] got;
      it  = sb.pop_front();
      got = {yEqual, xEqual, southHop, northHop, westHop, eastHop};
      compared++;
      if (got !== it.expVec) begin
        mismatched++;
        $display("FAIL %s: cur=%h dst=%h en=%0b sel=%0d flags actual=%h expected=%h",
                 it.vecTag, curAddr, dstAddr, injEn, injSel, got, it.expVec);
      end
      compared++;
      if (faultDet !== it.expFault) begin
        mismatched++;
        $display("FAIL %s: cur=%h dst=%h en=%0b sel=%0d faultDet actual=%0b expected=%0b",
                 it.faultTag, curAddr, dstAddr, injEn, injSel, faultDet, it.expFault);
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      mismatched++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // initial state: all-zero addresses, equal on both axes, no fault (R3, R6)
    drive(0, 0, 0, 0, 1'b0, 0, "R3", "R6");
    // directed fault patterns
    drive(8, 4, 2, 4, 1'b1, 2, "R5", "R7");   // west 6 plus east bit 2 forced
    drive(3, 1, 1, 9, 1'b1, 11, "R5", "R7");  // north 8 plus south bit 2 forced
    drive(0, 5, 1, 5, 1'b1, 2, "R5", "R8");   // east 1 plus east bit 2 forced
    drive(9, 0, 5, 0, 1'b1, 4, "R5", "R8");   // west 4 plus west bit 1 cleared
    drive(6, 6, 6, 6, 1'b1, 12, "R5", "R9");  // equal with xEqual cleared
    drive(6, 2, 6, 3, 1'b1, 13, "R5", "R9");  // north 1 with yEqual forced
    drive(7, 7, 7, 7, 1'b1, 14, "R5", "R6");  // out-of-range select
    drive(7, 7, 7, 7, 1'b1, 15, "R5", "R6");
    // clean exhaustive sweep with a wandering select held off (R1 R2 R3 R4 R5)
    for (int c = 0; c < 256; c++) begin
      for (int d = 0; d < 256; d++) begin
        drive(c >> 4, c & 15, d >> 4, d & 15, 1'b0, d & 15, "R1 R2 R3 R4", "R6");
      end
    end
    // injected sweep: all X pairs, sixteen Y pairs, every select (R5 R10)
    for (int cx = 0; cx < 16; cx++) begin
      for (int dx = 0; dx < 16; dx++) begin
        for (int y = 0; y < 16; y++) begin
          for (int s = 0; s < 16; s++) begin
            drive(cx, y, dx, (y * 5 + 3) & 15, 1'b1, s, "R5", "R10");
          end
        end
      end
    end
    driveDone = 1'b1;
    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule